// File: doc/BRIEF.md
# UART FIFO Service Interrupt Generator

This block decides when a UART asks the host for service on its transmit and receive paths. Each path has a FIFO of `DEPTH` entries. The FIFOs, the serializers and the bus decoder sit outside this block. They hand in the occupancy counts, a one-cycle pulse for every character that moves, and one-cycle pulses for host reads and writes.

A mode bit selects one of two interrupt policies. In that bit's register it sits at position 3, where 0 selects per-character operation and 1 selects block operation.

- **Per-character policy.** A side becomes pending for each character it moves. The host's data access clears that pending state.
- **Block policy.** Each side compares its FIFO fill against a programmable threshold, so software can fill or drain the FIFO in bursts. The receive side signals once the fill reaches its threshold. The transmit side signals while the fill is below its threshold.

When the FIFOs are disabled, the block always uses the per-character policy. Each side is gated by its own enable before the two are combined onto the single interrupt pin.

The block also produces two line-status flags. One reports that the transmit side can accept another character. The other reports that the transmitter has gone completely idle.

Top module: `uart_svc_irq`

## Requirements
- R1: While reset is asserted, `irq` is 0, `lsr_thre` is 1 and `lsr_temt` is 1, and both per-character pending flags are cleared.
- R2: The 2-bit trigger selection codes map to thresholds as follows: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. The same mapping applies to the transmit and receive selections.
- R3: The per-character policy is in force whenever `fifo_en`=1 and `blk_mode`=0. Under it, a pulse on `rx_char_evt` or `tx_char_evt` makes that side pending, and the pending side drives `irq` (if enabled) from the next cycle on.
- R4: Under the per-character policy, `host_rd` clears the receive pending flag and `host_wr` clears the transmit pending flag. If a character event arrives in the same cycle as the clearing access, the event wins and the side stays pending.
- R5: Under the block policy (`fifo_en`=1 and `blk_mode`=1), the receive source is active exactly when `rx_count` is at least the receive threshold.
- R6: Under the block policy, the transmit source is active exactly when `tx_count` is strictly below the transmit threshold.
- R7: `irq` equals (`rx_ien` AND receive source) OR (`tx_ien` AND transmit source). With an enable at 0, its source has no effect on `irq`, but a pending flag is kept and appears once the enable returns to 1.
- R8: With `fifo_en`=0, the per-character policy is used whatever the value of `blk_mode`.
- R9: `lsr_thre` is 1 when `tx_count` is below `DEPTH` with FIFOs enabled. With FIFOs disabled, it is 1 when `tx_count` is 0.
- R10: `lsr_temt` is 1 only when `tx_count` is 0 and `tsr_empty` is 1. It therefore never reads 1 while `lsr_thre` is 0.
- R11: The outputs `irq`, `lsr_thre` and `lsr_temt` are registered. Each one reflects the inputs sampled at the preceding rising clock edge.
- R12: Under the block policy, both pending flags are held cleared and character events are ignored. On a return to the per-character policy, no interrupt appears from events that arrived during block operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | FIFOs enabled |
| blk_mode | input | 1 | Policy select: 0 per-character, 1 block |
| tx_trig_sel | input | 2 | Transmit threshold code |
| rx_trig_sel | input | 2 | Receive threshold code |
| tx_count | input | $clog2(DEPTH+1) | Transmit FIFO fill |
| rx_count | input | $clog2(DEPTH+1) | Receive FIFO fill |
| tsr_empty | input | 1 | Transmit shift register idle |
| tx_ien | input | 1 | Transmit interrupt enable |
| rx_ien | input | 1 | Receive interrupt enable |
| rx_char_evt | input | 1 | Pulse: one character received |
| tx_char_evt | input | 1 | Pulse: one character sent |
| host_rd | input | 1 | Pulse: host read a received character |
| host_wr | input | 1 | Pulse: host wrote a transmit character |
| irq | output | 1 | Service interrupt |
| lsr_thre | output | 1 | Transmit side has a free location |
| lsr_temt | output | 1 | Transmitter completely empty |

## Verification
The bench builds the block with the default `DEPTH` of 16, which gives 5-bit counts. With that width it can drive every fill from 0 to a full FIFO. That brings within reach:

- each threshold from one below to exactly on it, for all four codes on both sides;
- the full-FIFO case that drops the holding-empty flag.

A bench-side model carries its own pending flags. It therefore also covers policy switches, event-versus-clear collisions in the same cycle, and a pending flag kept while its enable is off.

// File: rtl/uart_svc_pkg.sv
package uart_svc_pkg;

  // Threshold selected by a 2-bit trigger code.
  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // Receive side: signal once the fill has reached the threshold.
  function automatic logic rx_thr_hit(input int unsigned fill, input int unsigned lvl);
    return fill >= lvl;
  endfunction

  // Transmit side: signal while the fill is under the threshold.
  function automatic logic tx_thr_hit(input int unsigned fill, input int unsigned lvl);
    return fill < lvl;
  endfunction

endpackage

// File: rtl/uart_svc_side.sv
module uart_svc_side
  import uart_svc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit IS_RX = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_act,
  input  logic          char_evt,
  input  logic          host_clr,
  input  logic [CW-1:0] count,
  input  logic [1:0]    trig_sel,
  output logic          thr_hit,
  output logic          src_next
);

  logic        pend_q;
  logic        pend_d;
  int unsigned lvl;

  assign lvl = trig_level(trig_sel);

  generate
    if (IS_RX) begin : g_rx
      assign thr_hit = rx_thr_hit(32'(count), lvl);
    end else begin : g_tx
      assign thr_hit = tx_thr_hit(32'(count), lvl);
    end
  endgenerate

  // Pending flag: held clear in block mode; event beats clear.
  always_comb begin
    if (blk_act)       pend_d = 1'b0;
    else if (char_evt) pend_d = 1'b1;
    else if (host_clr) pend_d = 1'b0;
    else               pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign src_next = blk_act ? thr_hit : pend_d;

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_act && char_evt) |=> pend_q); // R3

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_act && host_clr && !char_evt) |=> !pend_q); // R4

  AST_BLK_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    blk_act |=> !pend_q); // R12

endmodule

// File: rtl/uart_svc_irq.sv
module uart_svc_irq
  import uart_svc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          blk_mode,
  input  logic [1:0]    tx_trig_sel,
  input  logic [1:0]    rx_trig_sel,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic          tsr_empty,
  input  logic          tx_ien,
  input  logic          rx_ien,
  input  logic          rx_char_evt,
  input  logic          tx_char_evt,
  input  logic          host_rd,
  input  logic          host_wr,
  output logic          irq,
  output logic          lsr_thre,
  output logic          lsr_temt
);

  logic blk_act;
  logic rx_hit_w, tx_hit_w;
  logic rx_src_next, tx_src_next;
  logic irq_d, thre_d, temt_d;

  assign blk_act = fifo_en & blk_mode;

  uart_svc_side #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_n), .blk_act(blk_act),
    .char_evt(rx_char_evt), .host_clr(host_rd),
    .count(rx_count), .trig_sel(rx_trig_sel),
    .thr_hit(rx_hit_w), .src_next(rx_src_next)
  );

  uart_svc_side #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx (
    .clk(clk), .rst_n(rst_n), .blk_act(blk_act),
    .char_evt(tx_char_evt), .host_clr(host_wr),
    .count(tx_count), .trig_sel(tx_trig_sel),
    .thr_hit(tx_hit_w), .src_next(tx_src_next)
  );

  assign irq_d  = (rx_ien & rx_src_next) | (tx_ien & tx_src_next);
  assign thre_d = fifo_en ? (tx_count < CW'(DEPTH)) : (tx_count == '0);
  assign temt_d = (tx_count == '0) & tsr_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      lsr_thre <= 1'b1;
      lsr_temt <= 1'b1;
    end else begin
      irq      <= irq_d;
      lsr_thre <= thre_d;
      lsr_temt <= temt_d;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(rx_ien) || $past(tx_ien))); // R7

  AST_BLK_RX_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_act && rx_ien && rx_hit_w) |=> irq); // R5

  AST_BLK_TX_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_act && tx_ien && tx_hit_w) |=> irq); // R6

  AST_FIFO_OFF_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_ien && rx_char_evt) |=> irq); // R8

  AST_TEMT_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_temt |-> lsr_thre); // R10

endmodule

// File: tb/uart_svc_irq_tb_top.sv
module uart_svc_irq_tb_top;

  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, blk_mode = 1'b0;
  logic [1:0] tx_trig_sel = '0, rx_trig_sel = '0;
  logic [CW-1:0] tx_count = '0, rx_count = '0;
  logic tsr_empty = 1'b1, tx_ien = 1'b0, rx_ien = 1'b0;
  logic rx_char_evt = 1'b0, tx_char_evt = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic irq, lsr_thre, lsr_temt;

  always #2 clk = ~clk;

  uart_svc_irq #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .blk_mode(blk_mode),
    .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
    .tx_count(tx_count), .rx_count(rx_count), .tsr_empty(tsr_empty),
    .tx_ien(tx_ien), .rx_ien(rx_ien), .rx_char_evt(rx_char_evt),
    .tx_char_evt(tx_char_evt), .host_rd(host_rd), .host_wr(host_wr),
    .irq(irq), .lsr_thre(lsr_thre), .lsr_temt(lsr_temt)
  );

  typedef struct {
    string tag;
    logic  irq;
    logic  thre;
    logic  temt;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // Stimulus staged by the sequence, applied by drive().
  logic s_fen = 0, s_blk = 0, s_tien = 0, s_rien = 0, s_tsr = 1;
  logic [1:0] s_tsel = 0, s_rsel = 0;
  int   s_txc = 0, s_rxc = 0;
  logic s_rev = 0, s_tev = 0, s_rd = 0, s_wr = 0;
  logic m_rp = 0, m_tp = 0;

  function automatic int lvl_of(logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 4 : (c == 2'b10) ? 8 : 14;
  endfunction

  task automatic drive(input string tag);
    exp_t e;
    logic chr, rs, ts;
    @(negedge clk);
    fifo_en = s_fen; blk_mode = s_blk; tx_ien = s_tien; rx_ien = s_rien;
    tsr_empty = s_tsr; tx_trig_sel = s_tsel; rx_trig_sel = s_rsel;
    tx_count = CW'(s_txc); rx_count = CW'(s_rxc);
    rx_char_evt = s_rev; tx_char_evt = s_tev; host_rd = s_rd; host_wr = s_wr;
    chr = !(s_fen && s_blk);
    if (!chr) begin
      m_rp = 0; m_tp = 0;
    end else begin
      if (s_rev) m_rp = 1; else if (s_rd) m_rp = 0;
      if (s_tev) m_tp = 1; else if (s_wr) m_tp = 0;
    end
    rs = chr ? m_rp : (s_rxc >= lvl_of(s_rsel));
    ts = chr ? m_tp : (s_txc < lvl_of(s_tsel));
    e.tag  = tag;
    e.irq  = (s_rien & rs) | (s_tien & ts);
    e.thre = s_fen ? (s_txc < DEPTH) : (s_txc == 0);
    e.temt = (s_txc == 0) && s_tsr;
    exp_q.push_back(e);
    s_rev = 0; s_tev = 0; s_rd = 0; s_wr = 0;
  endtask

  // Monitor: outputs settle one edge after drive (R11).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (irq !== e.irq || lsr_thre !== e.thre || lsr_temt !== e.temt) begin
          n_fail++;
          $display("FAIL %s R11: irq/thre/temt got %b%b%b expected %b%b%b",
                   e.tag, irq, lsr_thre, lsr_temt, e.irq, e.thre, e.temt);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (irq !== 1'b0 || lsr_thre !== 1'b1 || lsr_temt !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset: got %b%b%b expected 011", irq, lsr_thre, lsr_temt);
    end
    rst_n = 1'b1;

    // Per-character receive and transmit.
    s_fen = 1; s_rien = 1;
    drive("R1 idle after reset");
    s_rev = 1; drive("R3 rx event");
    drive("R3 rx pending held");
    s_rd = 1; drive("R4 host read clears");
    s_rev = 1; s_rd = 1; drive("R4 event beats read");
    s_rd = 1; drive("R4 read clears again");
    s_rien = 0; s_tien = 1;
    s_tev = 1; drive("R3 tx event");
    s_wr = 1; drive("R4 host write clears");
    s_tev = 1; s_wr = 1; drive("R4 tx event beats write");
    s_wr = 1; drive("R4 write clears");

    // Enable gating keeps pending state.
    s_tien = 0; s_rien = 0;
    s_rev = 1; drive("R7 rx disabled");
    drive("R7 still masked");
    s_rien = 1; drive("R7 pending shows on enable");
    s_rd = 1; drive("R7 cleared");

    // Block mode, receive thresholds.
    s_blk = 1; s_rien = 1; s_tien = 0;
    for (int c = 0; c < 4; c++) begin
      s_rsel = 2'(c);
      s_rxc = lvl_of(2'(c)) - 1; drive($sformatf("R5 R2 rx code %0d below", c));
      s_rxc = lvl_of(2'(c));     drive($sformatf("R5 R2 rx code %0d at", c));
    end
    s_rxc = DEPTH; drive("R5 rx full");
    s_rxc = 0;

    // Block mode, transmit thresholds.
    s_rien = 0; s_tien = 1;
    for (int c = 0; c < 4; c++) begin
      s_tsel = 2'(c);
      s_txc = lvl_of(2'(c));     drive($sformatf("R6 R2 tx code %0d at", c));
      s_txc = lvl_of(2'(c)) - 1; drive($sformatf("R6 R2 tx code %0d below", c));
    end

    // Character events ignored in block mode.
    s_tien = 0; s_rien = 1; s_txc = 0;
    s_rev = 1; drive("R12 rx event in block mode");
    s_blk = 0; drive("R12 no stale pending");

    // FIFOs off force per-character policy.
    s_fen = 0; s_blk = 1; s_rxc = DEPTH;
    s_rev = 1; drive("R8 fifo off event");
    s_rd = 1; drive("R8 fifo off clear");

    // Line status.
    s_rien = 0; s_fen = 1; s_blk = 0;
    s_txc = DEPTH; drive("R9 tx full");
    s_txc = DEPTH - 1; drive("R9 one free");
    s_txc = 0; s_tsr = 0; drive("R10 shifter busy");
    s_tsr = 1; drive("R10 all empty");
    s_fen = 0; s_txc = 1; drive("R9 fifo off one held");
    s_txc = 0; drive("R9 fifo off empty");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule